// File: doc/BRIEF.md
# Priority Scrub Group Scheduler

This block plans and paces scrub passes over a storage array that is divided into numbered sectors. Each sector is marked as high priority or normal by a mask input. The block splits both classes into groups that fit a fixed budget of concurrent scan slots. It then steps through those groups, one time step at a time. In every step it presents a set of sector numbers, each on its own slot lane with a valid bit, to an external scan engine. It holds that set until the engine reports the step finished.

Group k of the high priority class and group k of the normal class share step k. High priority groups are few, so their index wraps much sooner, and critical sectors are rescanned many times in one full pass over the normal sectors. The mask is captured only when a pass begins. A warning output reports masks that make the high priority class slower to cover than the normal one.

Top module: `priority_scrub_sched`

## Requirements
- R1: While rst_n is low, and until step_valid first rises, step_valid, every slot_vld bit, cycle_done and cfg_warn are 0. step_valid rises after the third rising clock edge that follows the release of rst_n, and step_done has no effect before then.
- R2: With P marked sectors and N = NUM_SECT - P unmarked ones, the group counts are as follows. If P <= SMAX-1, then GP = 1 and there are PS = P priority slots. Otherwise GP = ceil(P/(SMAX-1)) and PS = ceil(P/GP). There are SMAX-PS normal slots, and GN = ceil(N/(SMAX-PS)), which is 0 when N = 0. One pass takes max(GP,GN) acknowledged steps.
- R3: Slots 0..PS-1 have slot_hi=1 and the remaining slots have slot_hi=0. Slot s of priority group g carries the sector with rank g*PS+s among the marked sectors. Slot s >= PS in step k carries the sector with rank k*(SMAX-PS)+(s-PS) among the unmarked sectors. Ranks count up from the lowest sector index. slot_id lane s occupies bits [s*5 +: 5].
- R4: The priority group index is 0 at the start of each pass and advances by one per acknowledged step, modulo GP. A priority slot is valid only if its rank exists.
- R5: The normal group index equals the step number within the pass. Normal slots are invalid in steps k >= GN and wherever their rank does not exist.
- R6: While step_valid is 1 and step_done is 0, all slot outputs hold. A rising edge with step_done=1 moves to the next step.
- R7: cycle_done is high for exactly the one cycle that follows the edge at which the last step of a pass is acknowledged. The next pass starts in that same cycle.
- R8: prio_mask is sampled only when a pass begins. A change during a pass has no effect on slot outputs or cfg_warn until the next pass.
- R9: While step_valid is 1, cfg_warn is 1 exactly when N > 0 and GP > GN for the mask captured for the current pass.
- R10: P = 0 and N = 0 are legal. With P = 0 all slots serve normal sectors. With N = 0 no normal slot is ever valid and cfg_warn stays 0.
- R11: At most SMAX-1 slots with slot_hi=1 are valid in any step, and no slot is valid while step_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| prio_mask | input | NUM_SECT | Bit i set marks sector i as high priority |
| step_done | input | 1 | Scan engine reports the current step finished |
| step_valid | output | 1 | A step is being presented |
| slot_vld | output | SMAX | Per-slot valid |
| slot_hi | output | SMAX | Per-slot class, 1 for a high priority slot |
| slot_id | output | SMAX*5 | Sector number for each slot, 5 bits per lane |
| cycle_done | output | 1 | One-cycle pulse at the start of each new pass |
| cfg_warn | output | 1 | High priority coverage slower than normal coverage |

## Verification
The hardest situation to reach is a mask change that arrives in the middle of a long pass. It must stay invisible until the wrap, while acknowledgements arrive at irregular times. The stimulus swaps the mask partway through every phase and answers steps with an irregular step_done pattern that includes a long stall. The reference model keeps its own captured mask, so the step that follows each wrap shows the new grouping. The masks cover empty, full, below-threshold, just-over-threshold and warning cases.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

  // Ceiling division on small non-negative counts; a zero divisor yields 0.
  function automatic int cdiv(input int a, input int b);
    if (b <= 0) return 0;
    return (a + b - 1) / b;
  endfunction

endpackage

// File: rtl/scrub_plan.sv
// Derives group counts and slot split from a captured priority mask.
module scrub_plan #(
  parameter int NUM_SECT = 30,
  parameter int SMAX     = 5,
  parameter int CW       = 5
) (
  input  logic [NUM_SECT-1:0] mask,
  output logic [CW-1:0]       gp,
  output logic [CW-1:0]       gn,
  output logic [CW-1:0]       ps,
  output logic [CW-1:0]       len,
  output logic                warn
);
  import scrub_pkg::*;

  always_comb begin
    int p, n, g, s, q;
    p = $countones(mask);
    n = NUM_SECT - p;
    if (p <= SMAX - 1) begin
      g = 1;
      s = p;
    end else begin
      g = cdiv(p, SMAX - 1);
      s = cdiv(p, g);
    end
    q    = cdiv(n, SMAX - s);
    gp   = CW'(g);
    ps   = CW'(s);
    gn   = CW'(q);
    len  = CW'((g > q) ? g : q);
    warn = (n > 0) && (g > q);
  end

endmodule

// File: rtl/scrub_seq.sv
// Step sequencer: pass start, step counter, priority group counter.
module scrub_seq #(
  parameter int NUM_SECT = 30,
  parameter int CW       = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SECT-1:0] mask_in,
  input  logic                step_done,
  input  logic [CW-1:0]       gp,
  input  logic [CW-1:0]       len,
  output logic                run,
  output logic [NUM_SECT-1:0] cfg_q,
  output logic [CW-1:0]       k_q,
  output logic [CW-1:0]       pg_q,
  output logic                cycle_done
);
  logic                run_q, cd_q, cd_d, en, wrap;
  logic [NUM_SECT-1:0] cfg_d;
  logic [CW-1:0]       k_d, pg_d;

  always_comb begin
    en    = !run_q || step_done;
    wrap  = run_q && (k_q == len - CW'(1));
    cfg_d = cfg_q;
    k_d   = k_q;
    pg_d  = pg_q;
    if (!run_q || wrap) begin
      cfg_d = mask_in;
      k_d   = '0;
      pg_d  = '0;
    end else begin
      k_d  = k_q + CW'(1);
      pg_d = (pg_q == gp - CW'(1)) ? '0 : pg_q + CW'(1);
    end
    cd_d = wrap && step_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cd_q  <= 1'b0;
      cfg_q <= '0;
      k_q   <= '0;
      pg_q  <= '0;
    end else begin
      run_q <= 1'b1;
      cd_q  <= cd_d;
      if (en) begin
        cfg_q <= cfg_d;
        k_q   <= k_d;
        pg_q  <= pg_d;
      end
    end
  end

  assign run        = run_q;
  assign cycle_done = cd_q;

endmodule

// File: rtl/scrub_slot_map.sv
// Per-slot rank lookup: finds the sector of a given rank within its class.
module scrub_slot_map #(
  parameter int NUM_SECT = 30,
  parameter int SMAX     = 5,
  parameter int IDW      = 5,
  parameter int CW       = 5
) (
  input  logic [NUM_SECT-1:0] mask,
  input  logic                run,
  input  logic [CW-1:0]       ps,
  input  logic [CW-1:0]       gn,
  input  logic [CW-1:0]       pg,
  input  logic [CW-1:0]       k,
  output logic [SMAX-1:0]     vld,
  output logic [SMAX-1:0]     hi,
  output logic [SMAX*IDW-1:0] id
);

  for (genvar s = 0; s < SMAX; s++) begin : g_slot
    logic           v, h;
    logic [IDW-1:0] d;

    always_comb begin
      int   rank, cnt;
      logic ok, hit;
      h = (s < int'(ps));
      if (h) begin
        rank = int'(pg) * int'(ps) + s;
        ok   = 1'b1;
      end else begin
        rank = int'(k) * (SMAX - int'(ps)) + (s - int'(ps));
        ok   = (int'(k) < int'(gn));
      end
      cnt = 0;
      hit = 1'b0;
      d   = '0;
      for (int i = 0; i < NUM_SECT; i++) begin
        if (mask[i] == h) begin
          if (cnt == rank) begin
            d   = IDW'(i);
            hit = 1'b1;
          end
          cnt++;
        end
      end
      v = run && ok && hit;
    end

    assign vld[s]            = v;
    assign hi[s]             = h;
    assign id[s*IDW +: IDW]  = d;
  end

endmodule

// File: rtl/priority_scrub_sched.sv
module priority_scrub_sched #(
  parameter  int NUM_SECT = 30,
  parameter  int SMAX     = 5,
  localparam int IDW      = $clog2(NUM_SECT),
  localparam int CW       = $clog2(NUM_SECT + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SECT-1:0] prio_mask,
  input  logic                step_done,
  output logic                step_valid,
  output logic [SMAX-1:0]     slot_vld,
  output logic [SMAX-1:0]     slot_hi,
  output logic [SMAX*IDW-1:0] slot_id,
  output logic                cycle_done,
  output logic                cfg_warn
);
  logic [1:0]          rsync_q;
  logic                rst_i, run, warn;
  logic [NUM_SECT-1:0] cfg_q;
  logic [CW-1:0]       gp, gn, ps, len, k_q, pg_q;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  scrub_plan #(.NUM_SECT(NUM_SECT), .SMAX(SMAX), .CW(CW)) u_plan (
    .mask(cfg_q), .gp(gp), .gn(gn), .ps(ps), .len(len), .warn(warn)
  );

  scrub_seq #(.NUM_SECT(NUM_SECT), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_i), .mask_in(prio_mask), .step_done(step_done),
    .gp(gp), .len(len), .run(run), .cfg_q(cfg_q), .k_q(k_q), .pg_q(pg_q),
    .cycle_done(cycle_done)
  );

  scrub_slot_map #(.NUM_SECT(NUM_SECT), .SMAX(SMAX), .IDW(IDW), .CW(CW)) u_map (
    .mask(cfg_q), .run(run), .ps(ps), .gn(gn), .pg(pg_q), .k(k_q),
    .vld(slot_vld), .hi(slot_hi), .id(slot_id)
  );

  assign step_valid = run;
  assign cfg_warn   = run && warn;

endmodule

// File: rtl/priority_scrub_sched_sva.sv
module priority_scrub_sched_sva #(
  parameter int SMAX = 5,
  parameter int IDW  = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                step_valid,
  input logic                step_done,
  input logic [SMAX-1:0]     slot_vld,
  input logic [SMAX-1:0]     slot_hi,
  input logic [SMAX*IDW-1:0] slot_id,
  input logic                cycle_done,
  input logic                cfg_warn
);

  AST_PRIO_SLOT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_vld & slot_hi) <= SMAX - 1); // R11

  AST_IDLE_NO_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
    !step_valid |-> (slot_vld == '0) && !cycle_done && !cfg_warn); // R1

  AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && !step_done) |=> step_valid && $stable(slot_vld) && $stable(slot_id) && $stable(slot_hi)); // R6

  AST_PASS_END_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |-> $past(step_valid && step_done)); // R7

  AST_WARN_HELD_IN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && $past(step_valid) && !cycle_done) |-> $stable(cfg_warn)); // R8

endmodule

bind priority_scrub_sched priority_scrub_sched_sva #(.SMAX(SMAX), .IDW(IDW)) u_sva (
  .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .step_done(step_done),
  .slot_vld(slot_vld), .slot_hi(slot_hi), .slot_id(slot_id),
  .cycle_done(cycle_done), .cfg_warn(cfg_warn)
);

// File: tb/priority_scrub_sched_test.sv
`timescale 1ns/1ps
module priority_scrub_sched_test;
  localparam int NS = 30;
  localparam int SM = 5;
  localparam int IW = 5;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NS-1:0]   prio_mask;
  logic            step_done;
  logic            step_valid, cycle_done, cfg_warn;
  logic [SM-1:0]   slot_vld, slot_hi;
  logic [SM*IW-1:0] slot_id;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  priority_scrub_sched uut (
    .clk(clk), .rst_n(rst_n), .prio_mask(prio_mask), .step_done(step_done),
    .step_valid(step_valid), .slot_vld(slot_vld), .slot_hi(slot_hi),
    .slot_id(slot_id), .cycle_done(cycle_done), .cfg_warn(cfg_warn)
  );

  // Planning arithmetic taken straight from the requirement text (R2).
  task automatic plan(input logic [NS-1:0] m, output int gp, output int gn,
                      output int ps, output int len, output int wr);
    int p, n;
    p = $countones(m);
    n = NS - p;
    if (p <= SM - 1) begin gp = 1; ps = p; end
    else begin gp = (p + SM - 2) / (SM - 1); ps = (p + gp - 1) / gp; end
    gn  = (n + (SM - ps) - 1) / (SM - ps);
    len = (gp > gn) ? gp : gn;
    wr  = (n > 0 && gp > gn) ? 1 : 0;
  endtask

  // Reference model state
  bit            m_run, m_cd;
  int            m_rel, m_k, m_pg, m_acks, m_last_len;
  logic [NS-1:0] m_cfg;

  always @(posedge clk or negedge rst_n) begin
    int gp, gn, ps, len, wr;
    if (!rst_n) begin
      m_run = 0; m_cd = 0; m_rel = 0; m_k = 0; m_pg = 0; m_acks = 0;
    end else if (!m_run) begin
      m_cd = 0;
      m_rel++;
      if (m_rel == 3) begin m_run = 1; m_cfg = prio_mask; m_k = 0; m_pg = 0; end
    end else begin
      m_cd = 0;
      if (step_done) begin
        plan(m_cfg, gp, gn, ps, len, wr);
        m_acks++;
        if (m_k == len - 1) begin
          m_cd = 1; m_last_len = len;
          m_cfg = prio_mask; m_k = 0; m_pg = 0;
        end else begin
          m_k++;
          m_pg = (m_pg + 1) % gp;
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    int gp, gn, ps, len, wr, p, n, r, ev, eid;
    int pq[$], nq[$];
    string tag;
    plan(m_cfg, gp, gn, ps, len, wr);
    p = $countones(m_cfg);
    n = NS - p;
    for (int i = 0; i < NS; i++) if (m_cfg[i]) pq.push_back(i); else nq.push_back(i);
    chk(m_run ? "R6" : "R1", step_valid, m_run);
    chk("R7", cycle_done, m_cd);
    chk((p == 0 || n == 0) ? "R10" : "R9", cfg_warn, m_run ? wr : 0);
    chk("R11", ($countones(slot_vld & slot_hi) <= SM - 1) ? 1 : 0, 1);
    for (int s = 0; s < SM; s++) begin
      if (!m_run) begin
        chk("R1", slot_vld[s], 0);
      end else begin
        if (s < ps) begin
          r = m_pg * ps + s; ev = (r < pq.size()) ? 1 : 0; eid = ev ? pq[r] : 0;
          tag = (p == 0 || n == 0) ? "R10" : "R4";
        end else begin
          r = m_k * (SM - ps) + (s - ps);
          ev = (m_k < gn && r < nq.size()) ? 1 : 0; eid = ev ? nq[r] : 0;
          tag = (p == 0 || n == 0) ? "R10" : "R5";
        end
        chk(tag, slot_vld[s], ev);
        chk("R3", slot_hi[s], (s < ps) ? 1 : 0);
        if (ev) chk((m_cfg != prio_mask) ? "R8" : "R3", slot_id[s*IW +: IW], eid);
      end
    end
    if (cycle_done) begin
      chk("R2", m_acks, m_last_len);
      m_acks = 0;
    end
  endtask

  localparam logic [NS-1:0] MASKS [7] = '{
    30'h0000_0000, 30'h0000_0003, 30'h2108_4210, 30'h0000_F000,
    30'h0000_001F, 30'h3FFF_FFFE, 30'h3FFF_FFFF };

  initial begin
    rst_n = 1'b0; prio_mask = 30'h0000_0003; step_done = 1'b1;
    repeat (3) begin @(negedge clk); compare(); end
    rst_n = 1'b1;
    for (int ph = 0; ph < 7; ph++) begin
      @(negedge clk); compare();
      prio_mask = MASKS[ph];
      for (int c = 0; c < 240; c++) begin
        @(negedge clk); compare();
        if (c == 110) prio_mask = MASKS[(ph + 3) % 7];
        if (ph == 2 && c >= 20 && c < 32) step_done = 1'b0;
        else step_done = ($urandom_range(0, 3) != 0);
      end
      if (ph == 4) begin
        rst_n = 1'b0;
        repeat (3) begin @(negedge clk); compare(); end
        rst_n = 1'b1;
      end
    end
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    finished = 1;
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

endmodule